// File: doc/BRIEF.md
# Packet Buffer Allocation Unit

This block keeps track of which buffers in a small packet pool are in use. A network controller's packet memory uses it to hand out buffer numbers. The host sends one-cycle commands with a 2-bit opcode. The commands are: take a buffer, give back the buffer named by the packet number register, and return the whole pool to its initial state. The unit tracks which buffers are free and holds a single outstanding request when the pool is empty. It also drives the host-visible packet number register, the allocation result register and an allocation-done interrupt status bit.

When an allocate command finds no free buffer, the request is kept rather than dropped. The result register shows the failure until a later release completes the request. The host issues allocate, waits for the interrupt bit, then reads the result. With the failure flag clear, the low seven bits of the result can be written unchanged into the packet number register.

Top module: `pkt_alloc_unit`

## Requirements
- R1: After the synchronous reset, the result register reads 0x80 (failure flag at bit 7 set, number 0), the packet number register reads 0 and the interrupt bit is 0.
- R2: An allocate command (opcode 1) with at least one free buffer and no outstanding request grants the lowest-numbered free buffer. On the next cycle the result reads the number in bits 1:0, with bit 7 and bits 6:2 clear, and the interrupt bit is set.
- R3: An allocate command with all four buffers in use sets bit 7 of the result and becomes the outstanding request. The number field and the interrupt bit are left unchanged.
- R4: A release command (opcode 2) that returns an in-use buffer while a request is outstanding grants that buffer to the request. On the next cycle the result reads that number with bit 7 clear, the interrupt bit is set, and the buffer stays in use.
- R5: An allocate command issued while a request is outstanding is ignored. The result does not change, and the next release completes the outstanding request only once.
- R6: A release of a buffer that is already free, or a release while the packet number register holds a value of 4 or more, has no effect on the pool or on any output.
- R7: The MMU reset command (opcode 3) marks all buffers free and cancels any outstanding request. On the next cycle the result reads 0x80, the packet number register 0 and the interrupt bit 0. The command overrides a packet number write or acknowledge given in the same cycle.
- R8: A host write sets the 7-bit packet number register on the next cycle. A release issued in the same cycle uses the value the register held before the write. A result value written back unchanged names the granted buffer.
- R9: The interrupt bit is cleared by an acknowledge strobe (write-one-to-clear). A grant in the same cycle as an acknowledge leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 2 | Opcode: 0 none, 1 allocate, 2 release, 3 MMU reset |
| pnr_we | input | 1 | Packet number register write strobe |
| pnr_wdata | input | 7 | Packet number register write data |
| irq_ack | input | 1 | Write-one-to-clear for the interrupt bit |
| pnr_q | output | 7 | Packet number register |
| result_q | output | 8 | Allocation result: bit 7 failed, bits 1:0 number |
| alloc_irq | output | 1 | Allocation-done interrupt status |

## Verification
The allocate path is tried with the pool filling from empty, which shows whether the lowest-free order holds. It is then tried with the pool full, which separates an immediate grant from a request left outstanding. Releases are made in several forms: of a busy buffer with and without a request outstanding, of a buffer already free, and with an out-of-range number. These cases separate a late grant from a plain return to the pool, and show which releases must do nothing. A long run of mixed commands, writes and acknowledges is compared every cycle against a behavioural model. That run exposes ordering faults between a command and a write or acknowledge that arrive together.

// File: rtl/pkt_alloc_pkg.sv
package pkt_alloc_pkg;
  typedef enum logic [1:0] {
    OP_NOP     = 2'd0,
    OP_ALLOC   = 2'd1,
    OP_FREE    = 2'd2,
    OP_MMU_RST = 2'd3
  } mmu_op_e;
endpackage

// File: rtl/pkt_alloc_freemap.sv
module pkt_alloc_freemap #(
  parameter int NUM_PKTS = 4,
  localparam int PN_W = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                all_free,
  input  logic                take_en,
  input  logic [PN_W-1:0]     take_idx,
  input  logic                give_en,
  input  logic [PN_W-1:0]     give_idx,
  output logic [NUM_PKTS-1:0] free_vec,
  output logic                any_free,
  output logic [PN_W-1:0]     low_idx
);
  logic [NUM_PKTS-1:0] free_q;

  // one flop per buffer: set when returned, cleared when handed out
  for (genvar i = 0; i < NUM_PKTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || all_free)
        free_q[i] <= 1'b1;
      else if (take_en && take_idx == PN_W'(i))
        free_q[i] <= 1'b0;
      else if (give_en && give_idx == PN_W'(i))
        free_q[i] <= 1'b1;
    end
  end

  // lowest free index wins
  always_comb begin
    low_idx = '0;
    for (int i = NUM_PKTS - 1; i >= 0; i--)
      if (free_q[i]) low_idx = PN_W'(i);
  end

  assign any_free = |free_q;
  assign free_vec = free_q;
endmodule

// File: rtl/pkt_alloc_regs.sv
module pkt_alloc_regs #(
  parameter int REG_W = 8,
  parameter int PN_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mmu_rst,
  input  logic             pnr_we,
  input  logic [REG_W-2:0] pnr_wdata,
  input  logic             grant,
  input  logic [PN_W-1:0]  grant_idx,
  input  logic             fail_set,
  input  logic             irq_ack,
  output logic [REG_W-2:0] pnr_q,
  output logic [REG_W-1:0] result_q,
  output logic             alloc_irq
);
  localparam int PAD_W = REG_W - 1 - PN_W;

  logic            fail_q;
  logic [PN_W-1:0] num_q;

  always_ff @(posedge clk) begin
    if (rst || mmu_rst) begin
      fail_q    <= 1'b1;
      num_q     <= '0;
      pnr_q     <= '0;
      alloc_irq <= 1'b0;
    end else begin
      if (grant) begin
        fail_q <= 1'b0;
        num_q  <= grant_idx;
      end else if (fail_set) begin
        fail_q <= 1'b1;
      end
      if (pnr_we) pnr_q <= pnr_wdata;
      if (grant)        alloc_irq <= 1'b1;
      else if (irq_ack) alloc_irq <= 1'b0;
    end
  end

  // upper number bits stay zero so the value copies straight into pnr
  assign result_q = {fail_q, {PAD_W{1'b0}}, num_q};
endmodule

// File: rtl/pkt_alloc_unit.sv
module pkt_alloc_unit
  import pkt_alloc_pkg::*;
#(
  parameter int NUM_PKTS = 4,
  parameter int REG_W    = 8,
  localparam int PN_W  = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1,
  localparam int PNR_W = REG_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             pnr_we,
  input  logic [PNR_W-1:0] pnr_wdata,
  input  logic             irq_ack,
  output logic [PNR_W-1:0] pnr_q,
  output logic [REG_W-1:0] result_q,
  output logic             alloc_irq
);
  logic                is_alloc, is_free, is_mmu_rst;
  logic                pending_q;
  logic [NUM_PKTS-1:0] free_vec;
  logic                any_free;
  logic [PN_W-1:0]     low_idx;
  logic [PN_W-1:0]     rel_idx;
  logic                rel_ok, alloc_now, alloc_wait, late_grant, give_en;
  logic                grant;
  logic [PN_W-1:0]     grant_idx;

  assign is_alloc   = cmd_valid && (mmu_op_e'(cmd_op) == OP_ALLOC);
  assign is_free    = cmd_valid && (mmu_op_e'(cmd_op) == OP_FREE);
  assign is_mmu_rst = cmd_valid && (mmu_op_e'(cmd_op) == OP_MMU_RST);

  assign rel_idx    = pnr_q[PN_W-1:0];
  assign rel_ok     = is_free && (pnr_q < PNR_W'(NUM_PKTS)) && !free_vec[rel_idx];
  assign alloc_now  = is_alloc && !pending_q && any_free;
  assign alloc_wait = is_alloc && !pending_q && !any_free;
  assign late_grant = rel_ok && pending_q;
  assign give_en    = rel_ok && !pending_q;
  assign grant      = alloc_now || late_grant;
  assign grant_idx  = alloc_now ? low_idx : rel_idx;

  always_ff @(posedge clk) begin
    if (rst || is_mmu_rst)  pending_q <= 1'b0;
    else if (alloc_wait)    pending_q <= 1'b1;
    else if (late_grant)    pending_q <= 1'b0;
  end

  pkt_alloc_freemap #(.NUM_PKTS(NUM_PKTS)) u_freemap (
    .clk      (clk),
    .rst      (rst),
    .all_free (is_mmu_rst),
    .take_en  (alloc_now),
    .take_idx (low_idx),
    .give_en  (give_en),
    .give_idx (rel_idx),
    .free_vec (free_vec),
    .any_free (any_free),
    .low_idx  (low_idx)
  );

  pkt_alloc_regs #(.REG_W(REG_W), .PN_W(PN_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .mmu_rst   (is_mmu_rst),
    .pnr_we    (pnr_we),
    .pnr_wdata (pnr_wdata),
    .grant     (grant),
    .grant_idx (grant_idx),
    .fail_set  (alloc_wait),
    .irq_ack   (irq_ack),
    .pnr_q     (pnr_q),
    .result_q  (result_q),
    .alloc_irq (alloc_irq)
  );
endmodule

// File: rtl/pkt_alloc_unit_chk.sv
module pkt_alloc_unit_chk #(
  parameter int REG_W = 8,
  localparam int PNR_W = REG_W - 1
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic             pnr_we,
  input logic [PNR_W-1:0] pnr_wdata,
  input logic             irq_ack,
  input logic [PNR_W-1:0] pnr_q,
  input logic [REG_W-1:0] result_q,
  input logic             alloc_irq
);
  localparam logic [REG_W-1:0] RES_IDLE = {1'b1, {(REG_W-1){1'b0}}};

  logic mmu_cmd, alloc_cmd;
  assign mmu_cmd   = cmd_valid && cmd_op == 2'd3;
  assign alloc_cmd = cmd_valid && cmd_op == 2'd1;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (result_q == RES_IDLE && pnr_q == '0 && !alloc_irq));

  // R7
  mmu_reset_chk: assert property (@(posedge clk) disable iff (rst)
    mmu_cmd |=> (result_q == RES_IDLE && pnr_q == '0 && !alloc_irq));

  // R8
  pnr_write_chk: assert property (@(posedge clk) disable iff (rst)
    (pnr_we && !mmu_cmd) |=> pnr_q == $past(pnr_wdata));

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(alloc_irq) |-> ($past(irq_ack) || $past(mmu_cmd) || $past(rst)));

  // R2
  grant_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(result_q[REG_W-1]) |-> alloc_irq);

  // R3
  fail_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(result_q[REG_W-1]) |-> ($past(alloc_cmd) || $past(mmu_cmd) || $past(rst)));

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_q) |-> ($past(cmd_valid) || $past(rst)));
endmodule

bind pkt_alloc_unit pkt_alloc_unit_chk #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .pnr_we    (pnr_we),
  .pnr_wdata (pnr_wdata),
  .irq_ack   (irq_ack),
  .pnr_q     (pnr_q),
  .result_q  (result_q),
  .alloc_irq (alloc_irq)
);

// File: tb/pkt_alloc_unit_bench.sv
`timescale 1ns/1ps
module pkt_alloc_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic       pnr_we = 1'b0;
  logic [6:0] pnr_wdata = 7'd0;
  logic       irq_ack = 1'b0;
  logic [6:0] pnr_q;
  logic [7:0] result_q;
  logic       alloc_irq;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  pkt_alloc_unit u_pkt_alloc_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .pnr_we(pnr_we), .pnr_wdata(pnr_wdata), .irq_ack(irq_ack),
    .pnr_q(pnr_q), .result_q(result_q), .alloc_irq(alloc_irq)
  );

  // behavioural reference
  bit  m_busy [4];
  bit  m_wait, m_fail, m_irq, m_live;
  int  m_num, m_pnr;

  always @(posedge clk) begin
    bit grant_now;
    int sel;
    grant_now = 0;
    m_live = 1;
    if (rst || (cmd_valid && cmd_op == 2'd3)) begin
      foreach (m_busy[k]) m_busy[k] = 0;
      m_wait = 0; m_fail = 1; m_num = 0; m_pnr = 0; m_irq = 0;
    end else begin
      if (cmd_valid && cmd_op == 2'd1 && !m_wait) begin
        sel = -1;
        for (int k = 3; k >= 0; k--) if (!m_busy[k]) sel = k;
        if (sel >= 0) begin
          m_busy[sel] = 1; m_fail = 0; m_num = sel; grant_now = 1;
        end else begin
          m_wait = 1; m_fail = 1;
        end
      end else if (cmd_valid && cmd_op == 2'd2 && m_pnr < 4) begin
        if (m_busy[m_pnr]) begin
          if (m_wait) begin
            m_wait = 0; m_fail = 0; m_num = m_pnr; grant_now = 1;
          end else begin
            m_busy[m_pnr] = 0;
          end
        end
      end
      if (pnr_we) m_pnr = pnr_wdata;
      if (grant_now) m_irq = 1;
      else if (irq_ack) m_irq = 0;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (m_live)
      check(phase, {result_q, pnr_q, alloc_irq},
            {m_fail, 5'd0, m_num[1:0], m_pnr[6:0], m_irq});
  end

  task automatic cmd(input logic [1:0] op, input bit ack = 0);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; irq_ack = ack;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0; irq_ack = 0;
  endtask

  task automatic wr_pnr(input logic [6:0] v);
    @(negedge clk);
    pnr_we = 1; pnr_wdata = v;
    @(negedge clk);
    pnr_we = 0;
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 result", result_q, 8'h80);
    check("R1 pnr", pnr_q, 0);
    check("R1 irq", alloc_irq, 0);
    rst = 0;

    phase = "R2";
    for (int k = 0; k < 4; k++) begin
      cmd(2'd1);
      check("R2 lowest free grant", result_q, k);
      check("R2 irq set", alloc_irq, 1);
      ack();
    end
    check("R9 ack clears irq", alloc_irq, 0);

    phase = "R3";
    cmd(2'd1);
    check("R3 failed flag", result_q, 8'h83);
    check("R3 irq unchanged", alloc_irq, 0);

    phase = "R5";
    cmd(2'd1);
    check("R5 alloc while pending ignored", result_q, 8'h83);

    phase = "R4";
    wr_pnr(7'd2);
    cmd(2'd2);
    check("R4 late grant number", result_q, 8'h02);
    check("R4 irq set on late grant", alloc_irq, 1);
    ack();
    phase = "R5";
    cmd(2'd1);
    check("R5 only one grant, pool still full", result_q, 8'h82);
    cmd(2'd3);

    phase = "R6";
    cmd(2'd1); cmd(2'd1); ack();
    wr_pnr(7'd9);
    cmd(2'd2);
    check("R6 out-of-range release no effect", result_q, 8'h01);
    wr_pnr(7'd3);
    cmd(2'd2);
    check("R6 free buffer release no effect", result_q, 8'h01);
    check("R6 irq untouched", alloc_irq, 0);
    cmd(2'd1);
    check("R6 pool unchanged, next is 2", result_q, 8'h02);

    phase = "R8";
    ack();
    wr_pnr(result_q[6:0]);
    check("R8 pnr write-back", pnr_q, 2);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'd2; pnr_we = 1; pnr_wdata = 7'd0;
    @(negedge clk);
    cmd_valid = 0; pnr_we = 0;
    check("R8 new pnr visible", pnr_q, 0);
    cmd(2'd1);
    check("R8 release used old pnr", result_q, 8'h02);

    phase = "R9";
    cmd(2'd1, 1);
    check("R9 grant beats ack", alloc_irq, 1);
    check("R9 granted 3", result_q, 8'h03);

    phase = "R7";
    cmd(2'd1);
    wr_pnr(7'd5);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'd3; pnr_we = 1; pnr_wdata = 7'd6;
    @(negedge clk);
    cmd_valid = 0; pnr_we = 0;
    check("R7 result", result_q, 8'h80);
    check("R7 pnr", pnr_q, 0);
    check("R7 irq", alloc_irq, 0);
    cmd(2'd1);
    check("R7 pool empty again", result_q, 8'h00);

    phase = "R2-mixed";
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      cmd_valid = ($urandom % 2) == 1;
      cmd_op = 2'($urandom % 4);
      if (cmd_op == 2'd3 && ($urandom % 16) != 0) cmd_op = 2'd1;
      pnr_we = ($urandom % 3) == 0;
      pnr_wdata = 7'($urandom % 6);
      irq_ack = ($urandom % 4) == 0;
    end
    @(negedge clk);
    cmd_valid = 0; pnr_we = 0; irq_ack = 0;
    @(negedge clk);
    summary();
  end
endmodule